// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block sits on a byte-wide register bus and controls an array of one-time-programmable fuses. The array has up to eight banks. Each bank holds a parameterised number of 8-bit rows. The row index field is eight bits wide, so a bank can address up to 256 rows. Software selects a target by writing two address registers. One carries the bank and the top of the row index. The other carries the rest of the row index and a bit select.

Software then writes a command code to start an operation. A sense copies the addressed row into a sense data register and into that row's shadow word. A burn sets one fuse bit to 1. A burn is accepted only while the key register holds the unlock value. Both operations keep the controller busy for a fixed, parameterised number of cycles.

Software polls the busy flag and then inspects the done and error bits. Both are cleared by writing ones to them. The fuse array is modelled as flops that can only change from 0 to 1, and reset clears them to the unburnt state. The shadow words of each bank can be read in a separate address window.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, every control register, the sense data and every shadow word read as 0.
- R2: The upper address register (offset 0x10) supplies the bank in bits [5:3] and row index bits [7:5] in bits [2:0]. The lower address register (offset 0x14) supplies row index bits [4:0] in bits [7:3] and the bit select in bits [2:0]. Both registers read back as written.
- R3: Writing 0x08 to the command register (offset 0x0C) while idle starts a sense. When the sense completes, the sense data register (offset 0x1C) and the addressed shadow word hold the row, and status bit 0 is set. The sense data register changes at no other time.
- R4: Writing 0x71 to the command register while idle, with the key register (offset 0x18) at 0xAA, burns the addressed bit. Only that bit changes, it becomes 1, and status bit 1 is set when the burn completes.
- R5: A burn command issued while the key register holds any value other than 0xAA leaves the array unchanged and never sets busy. It sets error bit 1 (error register at offset 0x08) instead. Writing 0x00 to the key register relocks the controller.
- R6: Status bit 7 (status register at offset 0x00) reads 1 for exactly OP_CYCLES cycles, starting with the cycle after the command is accepted.
- R7: A command written while busy is ignored. The running operation keeps its target and ends on schedule.
- R8: Status bits [1:0] are write-one-to-clear, and a completion in the same cycle as a clear wins. The mask register (offset 0x04) stores and returns bits [1:0] only.
- R9: Error bits 1 and 2 are write-one-to-clear, so writing 0xFE clears both. Error bit 0 always reads 0.
- R10: A sense, or an unlocked burn, whose row is at or above ROWS or whose bank is at or above BANKS does not start. It sets error bit 2 instead.
- R11: The shadow word of bank b, row n is read at byte address 0x800 + 0x400·b + 4·n, with the row value in bits [7:0] and 0 above. Unaligned or unmapped addresses read 0, and writes to the shadow window are ignored.
- R12: Fuse bits never return from 1 to 0. Burning a bit that is already 1 leaves the row unchanged.
- R13: Command codes other than 0x08 and 0x71 have no effect on busy, status, error or the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for one bus cycle |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 32 | Read data for addr, available in the same cycle |

## Verification
The bench goes after four cases:
- A burn command that arrives while a sense is still running. A design that restarted would change the target or stretch busy, and the bit would appear in the array.
- A burn attempted with the key closed. A leaky lock would set the fuse instead of raising error bit 1.
- A row beyond the configured depth. A design without the range check would alias onto a low row.
- Clearing done and error bits one at a time. A design that cleared whole registers would lose the bit that was not written.

It also burns the same bit twice and reads shadow words at aligned, unaligned and written-to addresses, so that a non-monotonic array or a writable shadow becomes visible.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam logic [7:0] REG_STAT  = 8'h00;
  localparam logic [7:0] REG_MASK  = 8'h04;
  localparam logic [7:0] REG_ERR   = 8'h08;
  localparam logic [7:0] REG_CMD   = 8'h0C;
  localparam logic [7:0] REG_UPA   = 8'h10;
  localparam logic [7:0] REG_LOA   = 8'h14;
  localparam logic [7:0] REG_KEY   = 8'h18;
  localparam logic [7:0] REG_SDATA = 8'h1C;
  localparam int unsigned CTRL_SPAN = 32;

  localparam logic [7:0] CMD_SENSE = 8'h08;
  localparam logic [7:0] CMD_BURN  = 8'h71;
  localparam logic [7:0] KEY_OPEN  = 8'hAA;

  localparam logic [15:0] SHADOW_BASE = 16'h0800;
  localparam int unsigned SHADOW_SHIFT = 10;

  typedef enum logic [1:0] {OP_NONE, OP_SENSE, OP_BURN} op_e;

  typedef struct packed {
    logic [2:0] bank;
    logic [7:0] row;
    logic [2:0] bitsel;
  } fuse_addr_t;

  typedef struct packed {
    logic       hit;
    logic [2:0] bank;
    logic [7:0] row;
  } shadow_sel_t;

  function automatic fuse_addr_t f_target(input logic [7:0] upa, input logic [7:0] loa);
    fuse_addr_t t;
    t.bank   = upa[5:3];
    t.row    = {upa[2:0], loa[7:3]};
    t.bitsel = loa[2:0];
    return t;
  endfunction

  function automatic logic [7:0] f_bitmask(input logic [2:0] b);
    return 8'(1) << b;
  endfunction

  function automatic logic f_in_range(input fuse_addr_t t, input int banks, input int rows);
    return (int'({29'd0, t.bank}) < banks) && (int'({24'd0, t.row}) < rows);
  endfunction

  function automatic shadow_sel_t f_shadow(input logic [15:0] a, input int banks, input int rows);
    shadow_sel_t s;
    logic [15:0] off;
    off    = a - SHADOW_BASE;
    s.bank = off[12:10];
    s.row  = off[9:2];
    s.hit  = (a >= SHADOW_BASE) && (a[1:0] == 2'b00) &&
             (int'({26'd0, off[15:10]}) < banks) && (int'({24'd0, off[9:2]}) < rows);
    return s;
  endfunction

endpackage

// File: rtl/otp_regfile.sv
module otp_regfile
  import otp_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic [7:0]        sdat,
  input  logic [1:0]        set_stat,
  input  logic [1:0]        set_err,
  output logic [7:0]        upa,
  output logic [7:0]        loa,
  output logic [7:0]        key,
  output logic              cmd_wr,
  output logic [1:0]        stat_bits,
  output logic [1:0]        err_bits,
  output logic              ctrl_hit,
  output logic [7:0]        ctrl_rdata
);

  logic [1:0] mask_q;
  logic       hit_w;
  logic [7:0] low_addr;

  assign ctrl_hit = ({{(32-ADDR_W){1'b0}}, addr} < 32'(CTRL_SPAN)) && (addr[1:0] == 2'b00);
  assign low_addr = addr[7:0];
  assign hit_w    = wr_en && ctrl_hit;
  assign cmd_wr   = hit_w && (low_addr == REG_CMD);

  logic w_stat, w_mask, w_err, w_upa, w_loa, w_key;
  assign w_stat = hit_w && (low_addr == REG_STAT);
  assign w_mask = hit_w && (low_addr == REG_MASK);
  assign w_err  = hit_w && (low_addr == REG_ERR);
  assign w_upa  = hit_w && (low_addr == REG_UPA);
  assign w_loa  = hit_w && (low_addr == REG_LOA);
  assign w_key  = hit_w && (low_addr == REG_KEY);

  logic [1:0] stat_clr, err_clr;
  assign stat_clr = w_stat ? wdata[1:0] : 2'b00;
  assign err_clr  = w_err  ? wdata[2:1] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_bits <= '0;
      err_bits  <= '0;
      mask_q    <= '0;
      upa       <= '0;
      loa       <= '0;
      key       <= '0;
    end else begin
      stat_bits <= (stat_bits & ~stat_clr) | set_stat;
      err_bits  <= (err_bits & ~err_clr) | set_err;
      if (w_mask) mask_q <= wdata[1:0];
      if (w_upa)  upa    <= wdata;
      if (w_loa)  loa    <= wdata;
      if (w_key)  key    <= wdata;
    end
  end

  always_comb begin
    ctrl_rdata = 8'h00;
    if (ctrl_hit) begin
      case (low_addr)
        REG_STAT:  ctrl_rdata = {busy, 5'b0, stat_bits};
        REG_MASK:  ctrl_rdata = {6'b0, mask_q};
        REG_ERR:   ctrl_rdata = {5'b0, err_bits, 1'b0};
        REG_UPA:   ctrl_rdata = upa;
        REG_LOA:   ctrl_rdata = loa;
        REG_KEY:   ctrl_rdata = key;
        REG_SDATA: ctrl_rdata = sdat;
        default:   ctrl_rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int BANKS     = 8,
  parameter int ROWS      = 32,
  parameter int OP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_code,
  input  logic [7:0] upa,
  input  logic [7:0] loa,
  input  logic [7:0] key,
  input  logic [7:0] fuse_byte,
  output logic       busy,
  output fuse_addr_t op_addr,
  output logic       sense_fire,
  output logic       burn_fire,
  output logic [7:0] sdat,
  output logic [1:0] set_stat,
  output logic [1:0] set_err
);

  localparam int CNT_W = (OP_CYCLES < 2) ? 1 : $clog2(OP_CYCLES);

  logic [CNT_W-1:0] left_q;
  op_e              kind_q;
  fuse_addr_t       tgt;
  logic             want_sense, want_burn, locked, in_range;
  logic             start, err_lock, err_range, op_end;

  assign tgt        = f_target(upa, loa);
  assign in_range   = f_in_range(tgt, BANKS, ROWS);
  assign locked     = (key != KEY_OPEN);
  assign want_sense = cmd_wr && !busy && (cmd_code == CMD_SENSE);
  assign want_burn  = cmd_wr && !busy && (cmd_code == CMD_BURN);
  assign err_lock   = want_burn && locked;
  assign err_range  = (want_sense || (want_burn && !locked)) && !in_range;
  assign start      = (want_sense || (want_burn && !locked)) && in_range;

  assign op_end     = busy && (left_q == '0);
  assign sense_fire = op_end && (kind_q == OP_SENSE);
  assign burn_fire  = op_end && (kind_q == OP_BURN);
  assign set_stat   = {burn_fire, sense_fire};
  assign set_err    = {err_range, err_lock};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      left_q  <= '0;
      kind_q  <= OP_NONE;
      op_addr <= '0;
      sdat    <= '0;
    end else begin
      if (start) begin
        busy    <= 1'b1;
        left_q  <= CNT_W'(OP_CYCLES - 1);
        kind_q  <= want_sense ? OP_SENSE : OP_BURN;
        op_addr <= tgt;
      end else if (busy) begin
        if (op_end) begin
          busy   <= 1'b0;
          kind_q <= OP_NONE;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end
      if (sense_fire) sdat <= fuse_byte;
    end
  end

endmodule

// File: rtl/otp_bank.sv
module otp_bank
  import otp_pkg::*;
#(
  parameter int ROWS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic [7:0] op_row,
  input  logic [7:0] bitmask,
  input  logic       sense_fire,
  input  logic       burn_fire,
  input  logic [7:0] rd_row,
  output logic [7:0] fuse_byte,
  output logic [7:0] shadow_byte
);

  localparam int ROW_W = (ROWS < 2) ? 1 : $clog2(ROWS);

  logic [7:0]       fuse_q   [ROWS];
  logic [7:0]       shadow_q [ROWS];
  logic [ROW_W-1:0] op_idx, rd_idx;

  assign op_idx      = ROW_W'(op_row);
  assign rd_idx      = ROW_W'(rd_row);
  assign fuse_byte   = fuse_q[op_idx];
  assign shadow_byte = shadow_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) begin
        fuse_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else if (sel) begin
      if (burn_fire)  fuse_q[op_idx]   <= fuse_q[op_idx] | bitmask;
      if (sense_fire) shadow_q[op_idx] <= fuse_q[op_idx];
    end
  end

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int BANKS     = 8,
  parameter int ROWS      = 32,
  parameter int OP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [31:0]       rdata
);

  logic [7:0]  upa, loa, key, sdat, fuse_byte, ctrl_rdata;
  logic        cmd_wr, busy, sense_fire, burn_fire, ctrl_hit;
  logic [1:0]  set_stat, set_err, stat_bits, err_bits;
  fuse_addr_t  op_addr;
  shadow_sel_t shs;
  logic [7:0]  fuse_bytes   [BANKS];
  logic [7:0]  shadow_bytes [BANKS];

  otp_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(busy), .sdat(sdat), .set_stat(set_stat), .set_err(set_err),
    .upa(upa), .loa(loa), .key(key), .cmd_wr(cmd_wr),
    .stat_bits(stat_bits), .err_bits(err_bits),
    .ctrl_hit(ctrl_hit), .ctrl_rdata(ctrl_rdata)
  );

  otp_seq #(.BANKS(BANKS), .ROWS(ROWS), .OP_CYCLES(OP_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(wdata),
    .upa(upa), .loa(loa), .key(key), .fuse_byte(fuse_byte),
    .busy(busy), .op_addr(op_addr), .sense_fire(sense_fire),
    .burn_fire(burn_fire), .sdat(sdat), .set_stat(set_stat), .set_err(set_err)
  );

  assign shs = f_shadow(16'(addr), BANKS, ROWS);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    otp_bank #(.ROWS(ROWS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .sel(op_addr.bank == 3'(b)),
      .op_row(op_addr.row),
      .bitmask(f_bitmask(op_addr.bitsel)),
      .sense_fire(sense_fire), .burn_fire(burn_fire),
      .rd_row(shs.row),
      .fuse_byte(fuse_bytes[b]),
      .shadow_byte(shadow_bytes[b])
    );
  end

  assign fuse_byte = fuse_bytes[op_addr.bank];

  always_comb begin
    rdata = 32'h0;
    if (ctrl_hit)     rdata = {24'h0, ctrl_rdata};
    else if (shs.hit) rdata = {24'h0, shadow_bytes[shs.bank]};
  end

endmodule

// File: rtl/otp_fuse_chk.sv
module otp_fuse_chk
  import otp_pkg::*;
#(
  parameter int OP_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cmd_wr,
  input logic [7:0] cmd_code,
  input logic [7:0] key,
  input fuse_addr_t op_addr,
  input logic       sense_fire,
  input logic       burn_fire,
  input logic [7:0] fuse_byte,
  input logic [7:0] sdat,
  input logic [1:0] err_bits
);

  int run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else        run <= busy ? run + 1 : 0;
  end

  // R5
  locked_burn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && cmd_code == CMD_BURN && key != KEY_OPEN) |=> (!busy && err_bits[0]));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < OP_CYCLES));

  // R6
  busy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == OP_CYCLES));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sense_fire && !burn_fire) |=> (busy && $stable(op_addr)));

  // R12
  fuse_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (($past(fuse_byte) & ~fuse_byte) == 8'h00));

  // R3
  sdat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_fire |=> $stable(sdat));

  // R13
  odd_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && cmd_code != CMD_SENSE && cmd_code != CMD_BURN) |=> !busy);

endmodule

bind otp_fuse_ctrl otp_fuse_chk #(.OP_CYCLES(OP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_wr(cmd_wr), .cmd_code(wdata),
  .key(key), .op_addr(op_addr), .sense_fire(sense_fire), .burn_fire(burn_fire),
  .fuse_byte(fuse_byte), .sdat(sdat), .err_bits(err_bits)
);

// File: tb/otp_fuse_ctrl_test.sv
module otp_fuse_ctrl_test;
  localparam int ADDR_W = 14, BANKS = 8, ROWS = 32, OPC = 4;
  localparam int A_STAT = 'h00, A_MASK = 'h04, A_ERR = 'h08, A_CMD = 'h0C;
  localparam int A_UPA = 'h10, A_LOA = 'h14, A_KEY = 'h18, A_SDAT = 'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [31:0] rdata;
  always #4 clk = ~clk;

  otp_fuse_ctrl #(.ADDR_W(ADDR_W), .BANKS(BANKS), .ROWS(ROWS), .OP_CYCLES(OPC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

  // behavioural reference
  bit [7:0] m_fuse [BANKS][ROWS];
  bit [7:0] m_shad [BANKS][ROWS];
  bit [7:0] m_upa, m_loa, m_key, m_sdat;
  bit [1:0] m_stat, m_mask;
  bit m_e1, m_e2, m_busy;
  int m_left, m_kind, m_b, m_r, m_bit;
  int nvec = 0, nbad = 0;
  logic [31:0] last_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_fuse[i, j]) begin m_fuse[i][j] = 0; m_shad[i][j] = 0; end
      m_upa = 0; m_loa = 0; m_key = 0; m_sdat = 0; m_stat = 0; m_mask = 0;
      m_e1 = 0; m_e2 = 0; m_busy = 0; m_left = 0; m_kind = 0;
    end else begin
      bit was_busy, fs, fb;
      int a, d, b, r;
      was_busy = m_busy; fs = 0; fb = 0;
      a = int'(addr); d = int'(wdata);
      if (m_busy) begin
        if (m_left == 0) begin
          m_busy = 0;
          if (m_kind == 1) fs = 1; else fb = 1;
        end else m_left--;
      end
      if (wr_en) begin
        case (a)
          A_STAT: m_stat = m_stat & ~2'(d);
          A_ERR: begin if (d[1]) m_e1 = 0; if (d[2]) m_e2 = 0; end
          A_MASK: m_mask = 2'(d);
          A_UPA: m_upa = 8'(d);
          A_LOA: m_loa = 8'(d);
          A_KEY: m_key = 8'(d);
          default: ;
        endcase
      end
      if (fs) begin
        m_sdat = m_fuse[m_b][m_r]; m_shad[m_b][m_r] = m_fuse[m_b][m_r]; m_stat[0] = 1;
      end
      if (fb) begin
        m_fuse[m_b][m_r][m_bit] = 1'b1; m_stat[1] = 1;
      end
      if (wr_en && a == A_CMD && !was_busy && (d == 'h08 || d == 'h71)) begin
        b = m_upa / 8;
        r = (m_upa % 8) * 32 + m_loa / 8;
        if (d == 'h71 && m_key != 8'hAA) m_e1 = 1;
        else if (b >= BANKS || r >= ROWS) m_e2 = 1;
        else begin
          m_busy = 1; m_left = OPC - 1; m_kind = (d == 'h08) ? 1 : 2;
          m_b = b; m_r = r; m_bit = m_loa % 8;
        end
      end
    end
  end

  function automatic int model_rd(int a);
    case (a)
      A_STAT: return (m_busy ? 128 : 0) + m_stat;
      A_MASK: return m_mask;
      A_ERR:  return (m_e2 ? 4 : 0) + (m_e1 ? 2 : 0);
      A_UPA:  return m_upa;
      A_LOA:  return m_loa;
      A_KEY:  return m_key;
      A_SDAT: return m_sdat;
      default: begin
        if (a >= 'h800 && a % 4 == 0) begin
          int off, b, r;
          off = a - 'h800; b = off / 1024; r = (off % 1024) / 4;
          if (b < BANKS && r < ROWS) return m_shad[b][r];
        end
        return 0;
      end
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (a == A_STAT) return "R6";
    if (a == A_ERR) return "R9";
    if (a == A_SDAT) return "R3";
    if (a >= 'h800) return "R11";
    return "R2";
  endfunction

  task automatic step(bit w, int a, int d);
    @(negedge clk);
    wr_en = w; addr = ADDR_W'(a); wdata = 8'(d);
    #2;
    last_rd = rdata;
    nvec++;
    if (int'(rdata) != model_rd(a)) begin
      nbad++;
      $display("FAIL %s addr %h: got %h expected %h (model)", tag_of(a), a, rdata, model_rd(a));
    end
  endtask

  task automatic expect_rd(int a, int exp, string tag);
    step(0, a, 0);
    nvec++;
    if (int'(last_rd) != exp) begin
      nbad++;
      $display("FAIL %s addr %h: got %h expected %h", tag, a, last_rd, exp);
    end
  endtask

  task automatic wait_idle(int exp_n, string tag);
    int n = 0;
    for (int k = 0; k < 100; k++) begin
      step(0, A_STAT, 0);
      if (last_rd[7]) n++; else break;
    end
    nvec++;
    if (n != exp_n) begin
      nbad++;
      $display("FAIL %s busy cycles: got %0d expected %0d", tag, n, exp_n);
    end
  endtask

  initial begin
    #800000;
    nbad++;
    $display("FAIL R6 watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(A_STAT, 0, "R1"); expect_rd(A_ERR, 0, "R1");
    expect_rd(A_KEY, 0, "R1");  expect_rd(A_SDAT, 0, "R1");
    expect_rd('h800, 0, "R1");
    // bank 2 row 5 sense
    step(1, A_UPA, 'h10); step(1, A_LOA, 'h28);
    step(1, A_CMD, 'h08);
    wait_idle(OPC, "R6");
    expect_rd(A_STAT, 'h01, "R3"); expect_rd(A_SDAT, 0, "R3");
    // R5 locked burn
    step(1, A_LOA, 'h2B); step(1, A_CMD, 'h71);
    expect_rd(A_STAT, 'h01, "R5"); expect_rd(A_ERR, 'h02, "R5");
    step(1, A_ERR, 'hFE); expect_rd(A_ERR, 0, "R9");
    // R4 unlocked burns of bits 3 and 6
    step(1, A_KEY, 'hAA);
    step(1, A_CMD, 'h71); wait_idle(OPC, "R4");
    expect_rd(A_STAT, 'h03, "R4");
    step(1, A_LOA, 'h2E); step(1, A_CMD, 'h71); wait_idle(OPC, "R4");
    step(1, A_LOA, 'h28); step(1, A_CMD, 'h08); wait_idle(OPC, "R3");
    expect_rd(A_SDAT, 'h48, "R4");
    expect_rd('h1014, 'h48, "R11");
    // R12 repeat burn
    step(1, A_LOA, 'h2B); step(1, A_CMD, 'h71); wait_idle(OPC, "R12");
    step(1, A_CMD, 'h08); wait_idle(OPC, "R12");
    expect_rd(A_SDAT, 'h48, "R12");
    // R7 command while busy
    step(1, A_LOA, 'h29); step(1, A_CMD, 'h08); step(1, A_CMD, 'h71);
    wait_idle(OPC - 1, "R7");
    step(1, A_CMD, 'h08); wait_idle(OPC, "R7");
    expect_rd(A_SDAT, 'h48, "R7");
    // R13 unknown code
    step(1, A_CMD, 'h55);
    expect_rd(A_STAT, 'h03, "R13"); expect_rd(A_ERR, 0, "R13");
    // R8 status and mask
    step(1, A_STAT, 'h01); expect_rd(A_STAT, 'h02, "R8");
    step(1, A_STAT, 'h02); expect_rd(A_STAT, 'h00, "R8");
    step(1, A_MASK, 'h03); expect_rd(A_MASK, 'h03, "R8");
    step(1, A_MASK, 'hFE); expect_rd(A_MASK, 'h02, "R8");
    // R10 row 40 beyond ROWS
    step(1, A_UPA, 'h11); step(1, A_LOA, 'h40); step(1, A_CMD, 'h08);
    expect_rd(A_STAT, 'h00, "R10"); expect_rd(A_ERR, 'h04, "R10");
    step(1, A_ERR, 'h02); expect_rd(A_ERR, 'h04, "R9");
    step(1, A_ERR, 'hFE); expect_rd(A_ERR, 'h00, "R9");
    // bank 7 row 31
    step(1, A_UPA, 'h38); step(1, A_LOA, 'hF8);
    step(1, A_CMD, 'h71); wait_idle(OPC, "R4");
    step(1, A_CMD, 'h08); wait_idle(OPC, "R3");
    expect_rd(A_SDAT, 'h01, "R3");
    expect_rd('h247C, 'h01, "R11"); expect_rd('h247D, 0, "R11");
    step(1, 'h247C, 'hFF); expect_rd('h247C, 'h01, "R11");
    expect_rd('h1014, 'h48, "R11");
    // R5 relock
    step(1, A_KEY, 'h00); step(1, A_LOA, 'hF9); step(1, A_CMD, 'h71);
    expect_rd(A_ERR, 'h02, "R5");
    step(1, A_LOA, 'hF8); step(1, A_CMD, 'h08); wait_idle(OPC, "R5");
    expect_rd(A_SDAT, 'h01, "R5");
    // R2 address registers read back
    expect_rd(A_UPA, 'h38, "R2"); expect_rd(A_LOA, 'hF8, "R2");
    step(0, A_STAT, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule